// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block keeps the characters of a multiplexed display in a 16-entry by 8-bit store and refreshes the display continuously. It follows a scan count that is shared with other logic. On each scan position it drives the byte stored for that digit as two 4-bit halves. A processor loads characters one byte at a time through a write strobe. A 2-bit mode input sets two things: whether 8 or 16 digits are in use, and whether new bytes are typed in from the left or pushed in from the right.

In left entry, each byte goes to a write pointer, which then advances and wraps at the last digit in use. In right entry, every byte moves the digits in use one place toward digit 0, and the new byte lands in the rightmost digit. Each half of the output can be blanked on its own. The output is also forced to zero for one clock whenever the digit being shown changes, so that one digit's data never appears on another digit's strobe.

Top module: `mux_display_refresh`

## Requirements
- R1: After reset both output halves are 0, every stored digit reads 0, the write pointer is at digit 0 and the remembered mode is 00.
- R2: In mode 00 (8 digits, left entry) successive writes fill digits 0,1,...,7 and the ninth write goes back to digit 0.
- R3: In mode 01 (16 digits, left entry) successive writes fill digits 0..15 and the seventeenth write goes back to digit 0.
- R4: In mode 10 (8 digits, right entry) a write moves digit i+1 into digit i for i = 0..6 and places the new byte in digit 7. Digits 8..15 are left unchanged.
- R5: In mode 11 (16 digits, right entry) a write moves digit i+1 into digit i for i = 0..14 and places the new byte in digit 15.
- R6: The digit shown is the scan count in 16-digit modes (mode bit 0 = 1) and the low three scan bits in 8-digit modes. disp_hi_o is bits 7:4 of that digit and disp_lo_o is bits 3:0. They are valid from the second rising edge after the scan input settles.
- R7: On the first rising edge that sees a changed digit address, with the mode unchanged, both output halves become 0 for one clock.
- R8: While blank_hi_i is 1, disp_hi_o is 0 from the next clock. disp_lo_o is unaffected.
- R9: While blank_lo_i is 1, disp_lo_o is 0 from the next clock. disp_hi_o is unaffected.
- R10: A change of mode returns the write pointer to digit 0 and leaves the stored digits unchanged.
- R11: In 8-digit modes a change of scan bit 3 alone is not a digit change: it causes no blank clock and selects the same digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bit 0: 16 digits when 1. Bit 1: right entry when 1 |
| wr_en_i | input | 1 | Write strobe for one byte per clock |
| wr_data_i | input | 8 | Character byte to store |
| scan_i | input | 4 | Shared scan count |
| blank_hi_i | input | 1 | Force the upper output half to zero |
| blank_lo_i | input | 1 | Force the lower output half to zero |
| disp_hi_o | output | 4 | Upper half of the shown digit |
| disp_lo_o | output | 4 | Lower half of the shown digit |

## Verification
The transition property assumes that the mode input does not change in the same clock as the scan count. A mode change alters the address mapping without any scan step, so whether the output blanks on that clock is left open. The stimulus therefore changes the mode only while the scan input is held, and it always waits several clocks before moving the scan again. Writes are never issued on the same clock as a mode change. This keeps the pointer reset free of conflicting updates, and the bench model can track the pointer exactly.

// File: rtl/mux_display_refresh_pkg.sv
package mux_display_refresh_pkg;

   typedef enum logic [1:0] {
      MODE_NARROW_LEFT  = 2'b00,
      MODE_WIDE_LEFT    = 2'b01,
      MODE_NARROW_RIGHT = 2'b10,
      MODE_WIDE_RIGHT   = 2'b11
   } disp_mode_e;

   function automatic logic mode_is_wide(input logic [1:0] m);
      return m[0];
   endfunction

   function automatic logic mode_is_right(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/mux_display_refresh_entry.sv
module mux_display_refresh_entry
   import mux_display_refresh_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              wr_en_i,
   output logic              put_o,
   output logic              shift_o,
   output logic [ADDR_W-1:0] put_addr_o,
   output logic [ADDR_W-1:0] last_idx_o
);
   localparam logic [ADDR_W-1:0] LAST_WIDE   = ADDR_W'(DEPTH - 1);
   localparam logic [ADDR_W-1:0] LAST_NARROW = ADDR_W'(DEPTH / 2 - 1);

   logic [1:0]        mode_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_eff;
   logic              mode_chg;

   assign mode_chg   = (mode_q != mode_i);
   assign ptr_eff    = mode_chg ? '0 : ptr_q;
   assign last_idx_o = mode_is_wide(mode_i) ? LAST_WIDE : LAST_NARROW;
   assign put_o      = wr_en_i && !mode_is_right(mode_i);
   assign shift_o    = wr_en_i &&  mode_is_right(mode_i);
   assign put_addr_o = ptr_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_NARROW_LEFT;
         ptr_q  <= '0;
      end else begin
         mode_q <= mode_i;
         if (put_o) begin
            ptr_q <= (ptr_eff == last_idx_o) ? '0 : ptr_eff + 1'b1;
         end else begin
            ptr_q <= ptr_eff;
         end
      end
   end
endmodule

// File: rtl/mux_display_refresh_store.sv
module mux_display_refresh_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              put_i,
   input  logic              shift_i,
   input  logic [ADDR_W-1:0] put_addr_i,
   input  logic [ADDR_W-1:0] last_idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem      [DEPTH];
   logic [DATA_W-1:0] neighbour[DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_nb
      if (gi < DEPTH - 1) begin : g_mid
         assign neighbour[gi] = mem[gi+1];
      end else begin : g_end
         assign neighbour[gi] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (shift_i) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (ADDR_W'(i) == last_idx_i)      mem[i] <= wdata_i;
            else if (ADDR_W'(i) < last_idx_i)  mem[i] <= neighbour[i];
         end
      end else if (put_i) begin
         mem[put_addr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem[rd_addr_i];
endmodule

// File: rtl/mux_display_refresh_out.sv
module mux_display_refresh_out #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [1:0]        blank_i,
   output logic [HALF_W-1:0] half_o [2]
);
   logic [ADDR_W-1:0] addr_q;
   logic              moving;

   always_ff @(posedge clk) addr_q <= addr_i;

   assign moving = (addr_q != addr_i);

   for (genvar gh = 0; gh < 2; gh++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       half_o[gh] <= '0;
         else if (moving || blank_i[gh])   half_o[gh] <= '0;
         else                              half_o[gh] <= rdata_i[gh*HALF_W +: HALF_W];
      end
   end
endmodule

// File: rtl/mux_display_refresh.sv
module mux_display_refresh
   import mux_display_refresh_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] scan_i,
   input  logic              blank_hi_i,
   input  logic              blank_lo_i,
   output logic [HALF_W-1:0] disp_hi_o,
   output logic [HALF_W-1:0] disp_lo_o
);
   if (DEPTH != (1 << ADDR_W) || DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("DATA_W must be even");
   end

   logic              put, shift;
   logic [ADDR_W-1:0] put_addr, last_idx, rd_addr;
   logic [DATA_W-1:0] rdata;
   logic [HALF_W-1:0] halves [2];

   assign rd_addr = mode_is_wide(mode_i) ? scan_i : {1'b0, scan_i[ADDR_W-2:0]};

   mux_display_refresh_entry #(.DEPTH(DEPTH)) u_entry (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_en_i(wr_en_i),
      .put_o(put), .shift_o(shift), .put_addr_o(put_addr), .last_idx_o(last_idx)
   );

   mux_display_refresh_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .put_i(put), .shift_i(shift),
      .put_addr_i(put_addr), .last_idx_i(last_idx), .wdata_i(wr_data_i),
      .rd_addr_i(rd_addr), .rdata_o(rdata)
   );

   mux_display_refresh_out #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
      .clk(clk), .rst_n(rst_n), .addr_i(rd_addr), .rdata_i(rdata),
      .blank_i({blank_hi_i, blank_lo_i}), .half_o(halves)
   );

   assign disp_lo_o = halves[0];
   assign disp_hi_o = halves[1];
endmodule

// File: rtl/mux_display_refresh_chk.sv
module mux_display_refresh_chk #(
   parameter int ADDR_W = 4,
   parameter int HALF_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_i,
   input logic [ADDR_W-1:0] scan_i,
   input logic              blank_hi_i,
   input logic              blank_lo_i,
   input logic [HALF_W-1:0] disp_hi_o,
   input logic [HALF_W-1:0] disp_lo_o
);
   logic [ADDR_W-1:0] seen_addr;
   assign seen_addr = mode_i[0] ? scan_i : {1'b0, scan_i[ADDR_W-2:0]};

   AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (disp_hi_o == '0 && disp_lo_o == '0)); // R1
   AST_BLANK_UPPER: assert property (@(posedge clk) disable iff (!rst_n) blank_hi_i |=> disp_hi_o == '0); // R8
   AST_BLANK_LOWER: assert property (@(posedge clk) disable iff (!rst_n) blank_lo_i |=> disp_lo_o == '0); // R9
   AST_STEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(seen_addr) && $stable(mode_i)) |-> ##0 1'b1 ##1 (disp_hi_o == '0 && disp_lo_o == '0)); // R7
endmodule

bind mux_display_refresh mux_display_refresh_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .scan_i(scan_i),
   .blank_hi_i(blank_hi_i), .blank_lo_i(blank_lo_i),
   .disp_hi_o(disp_hi_o), .disp_lo_o(disp_lo_o)
);

// File: tb/mux_display_refresh_tb.sv
module mux_display_refresh_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [3:0] scan = '0;
   logic       bh = 1'b0, bl = 1'b0;
   logic [3:0] dhi, dlo;

   int checks = 0, fails = 0;
   logic [7:0] model [16];
   int ptr = 0;

   always #10 clk = ~clk;

   mux_display_refresh u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .scan_i(scan), .blank_hi_i(bh), .blank_lo_i(bl), .disp_hi_o(dhi), .disp_lo_o(dlo)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int map_addr(input int s, input logic [1:0] m);
      return m[0] ? s : (s % 8);
   endfunction

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk);
      if (m != mode) ptr = 0;
      mode = m;
      @(negedge clk);
   endtask

   task automatic put(input logic [7:0] b);
      int n = mode[0] ? 16 : 8;
      @(negedge clk);
      wr_en = 1'b1; wr_data = b;
      if (mode[1]) begin
         for (int i = 0; i < n - 1; i++) model[i] = model[i+1];
         model[n-1] = b;
      end else begin
         model[ptr] = b;
         ptr = (ptr + 1) % n;
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic show(input int s, input string req);
      int prev = map_addr(scan, mode);
      int nxt  = map_addr(s, mode);
      logic [7:0] e;
      @(negedge clk);
      scan = 4'(s);
      @(negedge clk);
      if (prev != nxt) check("R7", {dhi, dlo}, 8'h00);
      else if (scan[3] != 1'b0 || s >= 8) check("R11", {dhi, dlo}, {bh ? 4'h0 : model[nxt][7:4], bl ? 4'h0 : model[nxt][3:0]});
      @(negedge clk);
      e = model[nxt];
      if (bh) e[7:4] = 4'h0;
      if (bl) e[3:0] = 4'h0;
      check(req, {dhi, dlo}, e);
   endtask

   initial begin
      #2_000_000;
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      check("R1", {dhi, dlo}, 8'h00);
      rst_n = 1'b1;
      set_mode(2'b01);
      for (int s = 0; s < 16; s++) show(s, "R1");

      set_mode(2'b00);
      for (int k = 0; k < 10; k++) put(8'(8'h30 + k * 7));
      for (int s = 0; s < 16; s++) show(s, "R2_R6");
      show(2, "R6"); show(10, "R11"); show(2, "R11");

      set_mode(2'b01);
      for (int k = 0; k < 20; k++) put(8'(8'hA1 + k * 13));
      for (int s = 0; s < 16; s++) show(s, "R3_R10");

      set_mode(2'b10);
      for (int k = 0; k < 3; k++) put(8'(8'h5C + k));
      for (int s = 0; s < 8; s++) show(s, "R4");
      set_mode(2'b01);
      for (int s = 8; s < 16; s++) show(s, "R4_R10");
      put(8'hE7);
      show(0, "R10");

      set_mode(2'b11);
      for (int k = 0; k < 5; k++) put(8'(8'h11 * (k + 1)));
      for (int s = 0; s < 16; s++) show(s, "R5");

      @(negedge clk); bh = 1'b1;
      for (int s = 15; s >= 0; s--) show(s, "R8");
      @(negedge clk); bh = 1'b0; bl = 1'b1;
      for (int s = 0; s < 16; s++) show(s, "R9");
      @(negedge clk); bl = 1'b0;
      show(3, "R6");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule